// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This controller-side block holds an asynchronous DRAM quiet after power-up and then wakes it with a fixed burst of refresh-type cycles. Normal traffic may start only after that burst. Once reset is released, the block keeps every strobe inactive for a pause that is derived from the clock frequency. It then issues a run of warm-up cycles on the active-low RAS, CAS and WE strobes, and finally raises `ready` to hand control to the normal arbiter.

The input `cbr_mode` selects the warm-up cycle type:

- **CAS-before-RAS:** CAS falls ahead of RAS and no address is driven. Choose this mode when the DRAM's internal refresh counter will be used later, because that counter is primed only if every warm-up cycle is of this kind.
- **RAS-only:** a row address is presented and stepped from zero, one row per cycle.

The block samples `cbr_mode` once, when the pause ends. The whole burst is therefore of one type.

States and transitions:

- `ST_PAUSE` waits the pause length, then moves to `ST_LEAD`.
- `ST_LEAD` is the lead-in of each cycle. In CAS-before-RAS mode CAS is already low here; in RAS-only mode the row address is set up here. It moves to `ST_STROBE`.
- `ST_STROBE` holds RAS low. It moves to `ST_PRECHG`.
- `ST_PRECHG` holds all strobes high. It returns to `ST_LEAD` until the last cycle, then moves to `ST_READY`.
- `ST_READY` holds until reset.

An asserted reset, from any state, returns the block to `ST_PAUSE`.

Top module: `dram_wakeup_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n` and `we_n` are 1, `row_addr` is 0 and `ready` is 0.
- R2: After reset release, `ras_n` and `cas_n` stay 1 for PAUSE_CLKS clock cycles. PAUSE_CLKS is PAUSE_NS multiplied by the clock frequency, rounded up to whole cycles (20000 cycles at the defaults, 200 us at 100 MHz).
- R3: Exactly WARMUP_CYCLES warm-up cycles (default 8) are issued. Each lasts LEAD_CLKS + STROBE_CLKS + PRECHG_CLKS clocks: lead-in, RAS low, then precharge with all strobes high.
- R4: With `cbr_mode`=1, `cas_n` goes to 0 at the start of the lead-in, LEAD_CLKS clocks before `ras_n` falls. Both stay 0 for STROBE_CLKS clocks and return to 1 together. `row_addr` stays 0.
- R5: With `cbr_mode`=0, `cas_n` stays 1. `row_addr` equals the cycle index, starting at 0 and rising by 1 per cycle. It is valid from the lead-in through the precharge of that cycle.
- R6: `cbr_mode` is sampled at the clock edge that ends the pause. Changes after that edge have no effect until the next reset.
- R7: `we_n` is 1 at all times.
- R8: `ready` rises in the first clock after the last precharge, which is PAUSE_CLKS + WARMUP_CYCLES×(cycle length) clocks after reset release. From then on the strobes are idle and `ready` stays 1 until reset.
- R9: Asserting reset at any time, including mid-warm-up or after `ready`, clears `ready` and restarts the full pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| cbr_mode | input | 1 | 1 = CAS-before-RAS warm-up, 0 = RAS-only warm-up |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held inactive) |
| row_addr | output | ROW_W | Row address for RAS-only warm-up cycles |
| ready | output | 1 | Initialization complete |

## Verification
The hardest situations to reach from the ports are those tied to the 20000-cycle pause boundary and to the middle of a burst. One is a `cbr_mode` change that arrives after the mode has been latched. Another is a reset landing partway through a warm-up cycle. The stimulus counts clock cycles from reset release to land each event a known number of cycles past the pause end. It flips `cbr_mode` inside the burst in both directions, and it asserts reset both during the warm-up and after `ready`. A behavioural model derives the expected strobe pattern from elapsed time alone and is compared with the outputs on every clock, so any early, late or reordered edge is reported.

// File: rtl/dram_wakeup_pkg.sv
package dram_wakeup_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_LEAD,
        ST_STROBE,
        ST_PRECHG,
        ST_READY
    } wake_state_e;

    // Whole clock cycles covering a duration, rounded up.
    function automatic int ns_to_clks(input longint dur_ns, input longint clk_hz);
        return int'((dur_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wakeup_interval_timer.sv
module wakeup_interval_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       elapsed <= '0;
        else if (restart) elapsed <= '0;
        else              elapsed <= elapsed + 1'b1;
    end

    assign expired = (elapsed == limit - 1'b1);
endmodule

// File: rtl/wakeup_cycle_tally.sv
module wakeup_cycle_tally #(
    parameter int COUNT = 8,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(COUNT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx <= '0;
        else if (step) idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/dram_wakeup_seq.sv
module dram_wakeup_seq
    import dram_wakeup_pkg::*;
#(
    parameter longint CLK_HZ        = 100_000_000,
    parameter longint PAUSE_NS      = 200_000,
    parameter int     WARMUP_CYCLES = 8,
    parameter int     LEAD_CLKS     = 1,
    parameter int     STROBE_CLKS   = 3,
    parameter int     PRECHG_CLKS   = 2,
    parameter int     ROW_W         = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cbr_mode,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             ready
);
    localparam int PAUSE_CLKS = ns_to_clks(PAUSE_NS, CLK_HZ);
    localparam int LONGEST    = max_of4(PAUSE_CLKS, LEAD_CLKS, STROBE_CLKS, PRECHG_CLKS);
    localparam int CW         = $clog2(LONGEST + 1);
    localparam int IW         = $clog2(WARMUP_CYCLES + 1);

    wake_state_e   state, state_nx;
    logic          mode_q;
    logic [CW-1:0] limit;
    logic          expired;
    logic          restart;
    logic [IW-1:0] cyc_idx;
    logic          cyc_last;
    logic          cyc_step;

    // Interval length of the current state
    always_comb begin
        unique case (state)
            ST_PAUSE:  limit = CW'(PAUSE_CLKS);
            ST_LEAD:   limit = CW'(LEAD_CLKS);
            ST_STROBE: limit = CW'(STROBE_CLKS);
            ST_PRECHG: limit = CW'(PRECHG_CLKS);
            default:   limit = CW'(1);
        endcase
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PAUSE:  if (expired) state_nx = ST_LEAD;
            ST_LEAD:   if (expired) state_nx = ST_STROBE;
            ST_STROBE: if (expired) state_nx = ST_PRECHG;
            ST_PRECHG: if (expired) state_nx = cyc_last ? ST_READY : ST_LEAD;
            default:   state_nx = ST_READY;
        endcase
    end

    assign restart  = (state_nx != state) || (state == ST_READY);
    assign cyc_step = (state == ST_PRECHG) && expired && !cyc_last;

    // State register and mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_PAUSE;
            mode_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_PAUSE && expired) mode_q <= cbr_mode;
        end
    end

    wakeup_interval_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .expired (expired)
    );

    wakeup_cycle_tally #(.COUNT(WARMUP_CYCLES), .IW(IW)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cyc_step),
        .idx   (cyc_idx),
        .last  (cyc_last)
    );

    // Outputs from state
    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        row_addr = '0;
        ready    = 1'b0;
        unique case (state)
            ST_PAUSE: ;
            ST_LEAD: begin
                cas_n = !mode_q;
                if (!mode_q) row_addr = ROW_W'(cyc_idx);
            end
            ST_STROBE: begin
                ras_n = 1'b0;
                cas_n = !mode_q;
                if (!mode_q) row_addr = ROW_W'(cyc_idx);
            end
            ST_PRECHG: begin
                if (!mode_q) row_addr = ROW_W'(cyc_idx);
            end
            default: ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/dram_wakeup_chk.sv
module dram_wakeup_chk #(
    parameter int PAUSE_CLKS    = 20000,
    parameter int WARMUP_CYCLES = 8,
    parameter int ROW_W         = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic [ROW_W-1:0] row_addr,
    input logic             ready
);
    localparam int SW = $clog2(PAUSE_CLKS + 1);
    localparam int FW = $clog2(WARMUP_CYCLES + 1);

    logic [SW-1:0] since_rst;
    logic [FW-1:0] ras_falls;
    logic          ras_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            ras_falls <= '0;
            ras_q     <= 1'b1;
        end else begin
            ras_q <= ras_n;
            if (since_rst != SW'(PAUSE_CLKS)) since_rst <= since_rst + 1'b1;
            if (ras_q && !ras_n && ras_falls != FW'(WARMUP_CYCLES)) ras_falls <= ras_falls + 1'b1;
        end
    end

    // R2
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < SW'(PAUSE_CLKS)) |-> (ras_n && cas_n));

    // R4
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !$fell(ras_n)) |-> $stable(row_addr));

    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready) |-> ready);

    // R3
    min_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_falls == FW'(WARMUP_CYCLES)));
endmodule

bind dram_wakeup_seq dram_wakeup_chk #(
    .PAUSE_CLKS    (PAUSE_CLKS),
    .WARMUP_CYCLES (WARMUP_CYCLES),
    .ROW_W         (ROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_addr (row_addr),
    .ready    (ready)
);

// File: tb/dram_wakeup_seq_test.sv
module dram_wakeup_seq_test;
    localparam int ROW_W   = 12;
    localparam int N       = 8;
    localparam int T_LEAD  = 1;
    localparam int T_RAS   = 3;
    localparam int T_RP    = 2;
    localparam int PAUSE_NS = 200_000;
    localparam int PER_NS   = 10;
    localparam int P   = (PAUSE_NS + PER_NS - 1) / PER_NS;
    localparam int CYC = T_LEAD + T_RAS + T_RP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cbr_mode = 1'b1;
    logic ras_n, cas_n, we_n, ready;
    logic [ROW_W-1:0] row_addr;

    dram_wakeup_seq #(
        .CLK_HZ(100_000_000), .PAUSE_NS(PAUSE_NS), .WARMUP_CYCLES(N),
        .LEAD_CLKS(T_LEAD), .STROBE_CLKS(T_RAS), .PRECHG_CLKS(T_RP), .ROW_W(ROW_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .row_addr(row_addr), .ready(ready)
    );

    always #5 clk = ~clk;

    int  checks = 0;
    int  fails  = 0;
    bit  done_flag = 0;
    int  t = 0;
    bit  lm = 0;
    bit  prev_ready = 0;
    bit  prev_ras = 1;
    int  falls = 0;
    int  rows[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at t=%0d: actual %0d expected %0d", req, what, t, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Reference model: advance time at the edge, compare shortly after.
    always @(posedge clk) begin
        bit e_ras, e_cas, e_rdy;
        int e_addr, u, idx, ph;
        string stag;
        if (!rst_n) t = 0;
        else begin
            if (t < 1_000_000) t = t + 1;
            if (t == P) lm = cbr_mode;
        end
        #2;
        e_ras = 1; e_cas = 1; e_rdy = 0; e_addr = 0; stag = "R1";
        if (rst_n) begin
            if (t < P) stag = "R2";
            else begin
                u = t - P; idx = u / CYC; ph = u % CYC;
                if (idx >= N) begin
                    e_rdy = 1; stag = "R8";
                end else begin
                    stag = (cbr_mode != lm) ? "R6" : (lm ? "R4" : "R5");
                    e_ras = !(ph >= T_LEAD && ph < T_LEAD + T_RAS);
                    e_cas = !(lm && ph < T_LEAD + T_RAS);
                    e_addr = lm ? 0 : idx;
                end
            end
        end
        chk(ras_n == e_ras, stag, "ras_n", ras_n, e_ras);
        chk(cas_n == e_cas, stag, "cas_n", cas_n, e_cas);
        chk(we_n == 1'b1, "R7", "we_n", we_n, 1);
        chk(row_addr == ROW_W'(e_addr), (stag == "R4" || stag == "R6") ? stag : "R5",
            "row_addr", row_addr, e_addr);
        chk(ready == e_rdy, rst_n ? "R8" : "R1", "ready", ready, e_rdy);
        if (!rst_n) begin
            falls = 0; rows.delete();
        end else if (prev_ras && !ras_n) begin
            falls++;
            if (!lm) rows.push_back(int'(row_addr));
        end
        if (rst_n && ready && !prev_ready) begin
            chk(t == P + N * CYC, "R8", "ready rise time", t, P + N * CYC);
            chk(falls == N, "R3", "warm-up count", falls, N);
        end
        prev_ras = ras_n;
        prev_ready = rst_n ? ready : 1'b0;
    end

    initial begin
        #(200_000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        cycles(3);
        chk(ras_n && cas_n && we_n && row_addr == 0 && !ready, "R1", "reset outputs",
            {ras_n, cas_n, we_n, ready}, 4'b1110);
        rst_n = 1'b1;

        // Run 1: CAS-before-RAS, mode flips mid-burst (R6)
        cycles(P + CYC * 2 + 1);
        cbr_mode = 1'b0;
        wait_ready();
        cycles(5);

        // R9: reset after ready
        rst_n = 1'b0;
        #1;
        chk(ready == 1'b0, "R9", "ready after reset", ready, 0);
        cycles(2);
        cbr_mode = 1'b0;
        rst_n = 1'b1;

        // Run 2: RAS-only, mode flips mid-burst
        cycles(P + CYC * 3);
        cbr_mode = 1'b1;
        wait_ready();
        chk(rows.size() == N, "R5", "row count", rows.size(), N);
        foreach (rows[i]) chk(rows[i] == i, "R5", "row sequence", rows[i], i);
        cycles(3);

        // Run 3: reset mid warm-up, then full CAS-before-RAS burst
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(P + CYC * 4 + 2);
        rst_n = 1'b0;
        #1;
        chk(ras_n && cas_n && !ready, "R9", "mid-burst reset", {ras_n, cas_n, ready}, 3'b110);
        cycles(2);
        rst_n = 1'b1;
        cycles(P - 5);
        chk(ras_n && cas_n && !ready, "R9", "pause restarted", {ras_n, cas_n, ready}, 3'b110);
        wait_ready();
        cycles(4);
        finish_run();
    end
endmodule